// File: doc/BRIEF.md
# Bit-Clock Source Selector

This block sits on the codec side of a serial audio link and settles, around each link reset, whether the codec takes the link bit clock from outside or generates it. While the link reset input is held low, it watches the bit-clock pin through a synchroniser on the master clock. A steady run of rising edges marks another device as the clock source, and the codec latches consumer mode.

If no activity has been seen when the link reset is released, a timeout starts. When the timeout expires with no edge on the pin, the codec latches driver mode. It then enables the pin's output driver and produces the bit clock by halving the master clock: a 24.576 MHz master clock gives a 12.288 MHz bit clock. The chosen mode holds until the link reset is asserted again, and the mode is reported on a status output.

All ports are plain level signals. Nothing streams through the block, so it has no valid/ready handshake and no back-pressure. The power-on reset `por_n` only initialises the logic. The link reset `link_rst_n` is the observed event.

Top module: `bclk_src_sel`

## Requirements
- R1: Status encoding on `src_mode_o`: 2'b00 undecided, 2'b01 consumer, 2'b10 driver; 2'b11 never appears. After power-on reset the status is 2'b00, and `bclk_oe` and `bclk_o` are 0.
- R2: While `link_rst_n` is low, EDGE_THRESH rising edges on `bclk_pin_i`, each within GAP_CYC master cycles of the previous one, latch consumer mode while the link reset is still held.
- R3: Rising edges spaced further apart than GAP_CYC master cycles do not add up, and a run shorter than EDGE_THRESH does not change the mode.
- R4: If the link reset is released with no mode latched and the pin stays idle, driver mode is latched exactly TIMEOUT_CYC+3 master cycles after the release (two synchroniser stages and one state register).
- R5: A single rising edge on the pin while the timeout runs restarts the timeout from zero.
- R6: A burst of EDGE_THRESH close edges arriving after release and before the timeout expires latches consumer mode.
- R7: In driver mode `bclk_oe` is 1 and `bclk_o` inverts on every master clock cycle (half the master frequency). Outside driver mode `bclk_o` is 0.
- R8: `bclk_oe` is 0 in the same cycle that `link_rst_n` is low, and it is always 0 in consumer or undecided mode.
- R9: A latched mode holds across the release of the link reset and until the link reset is next asserted. The status returns to 2'b00 on the third master clock edge after that assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master crystal clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| link_rst_n | input | 1 | Link reset being observed, active low, asynchronous to clk_mst |
| bclk_pin_i | input | 1 | Bit-clock pin as received |
| bclk_o | output | 1 | Generated bit clock, master clock divided by two |
| bclk_oe | output | 1 | Output enable for the bit-clock pin driver |
| src_mode_o | output | 2 | Clock source status (see R1) |

## Verification
The bench builds the block with EDGE_THRESH=3, GAP_CYC=12 and TIMEOUT_CYC=40. With these values, short and sparse edge trains can be set on either side of the gap limit, and the exact cycle of the driver decision can be reached in a few dozen cycles. The bench drives the pin with trains whose half period is 2 cycles for bursts and 20 cycles for sparse edges, so the two cases sit well apart from the 12-cycle gap.

// File: rtl/bclk_src_pkg.sv
package bclk_src_pkg;
  typedef enum logic [1:0] {
    MODE_UNDEC = 2'b00,
    MODE_CONS  = 2'b01,
    MODE_DRV   = 2'b10
  } src_mode_e;

  typedef enum logic [1:0] {
    ST_LISTEN,
    ST_WAIT,
    ST_CONS,
    ST_DRV
  } sel_state_e;
endpackage

// File: rtl/bclk_sync.sv
module bclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bclk_edge_count.sv
module bclk_edge_count #(
  parameter int EDGE_THRESH = 4,
  parameter int GAP_CYC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic clr,
  output logic rise,
  output logic active
);
  localparam int CW = $clog2(EDGE_THRESH + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic          pin_q;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;

  assign rise   = pin_s & ~pin_q;
  assign active = (cnt == CW'(EDGE_THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cnt   <= '0;
      gap   <= '0;
    end else begin
      pin_q <= pin_s;
      if (clr) begin
        cnt <= '0;
        gap <= '0;
      end else if (rise) begin
        gap <= '0;
        if (!active) cnt <= cnt + CW'(1);
      end else if (gap == GW'(GAP_CYC - 1)) begin
        cnt <= '0;
      end else begin
        gap <= gap + GW'(1);
      end
    end
  end
endmodule

// File: rtl/bclk_mode_fsm.sv
module bclk_mode_fsm
  import bclk_src_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rel_s,
  input  logic      rise,
  input  logic      active,
  output src_mode_e mode,
  output logic      clr,
  output logic      drv_en
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  sel_state_e    st;
  logic          rel_q;
  logic [TW-1:0] tmr;
  logic          assert_ev;

  assign assert_ev = rel_q & ~rel_s;
  assign clr       = assert_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_LISTEN;
      rel_q <= 1'b0;
      tmr   <= '0;
    end else begin
      rel_q <= rel_s;
      case (st)
        ST_LISTEN: begin
          tmr <= '0;
          if (active)     st <= ST_CONS;
          else if (rel_s) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (assert_ev)                          st  <= ST_LISTEN;
          else if (active)                        st  <= ST_CONS;
          else if (rise)                          tmr <= '0;
          else if (tmr == TW'(TIMEOUT_CYC - 1))   st  <= ST_DRV;
          else                                    tmr <= tmr + TW'(1);
        end
        default: begin
          if (assert_ev) st <= ST_LISTEN;
        end
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_CONS: mode = MODE_CONS;
      ST_DRV:  mode = MODE_DRV;
      default: mode = MODE_UNDEC;
    endcase
  end

  assign drv_en = (st == ST_DRV);
endmodule

// File: rtl/bclk_div2.sv
module bclk_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= ~q;
    else         q <= 1'b0;
  end

  assign bclk = q & en;
endmodule

// File: rtl/bclk_src_sel.sv
module bclk_src_sel
  import bclk_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_THRESH = 4,
  parameter int GAP_CYC     = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk_mst,
  input  logic       por_n,
  input  logic       link_rst_n,
  input  logic       bclk_pin_i,
  output logic       bclk_o,
  output logic       bclk_oe,
  output logic [1:0] src_mode_o
);
  logic      rel_s, pin_s, rise, active, clr, drv_en;
  src_mode_e mode;

  bclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk(clk_mst), .rst_n(por_n), .d(link_rst_n), .q(rel_s)
  );

  bclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk_mst), .rst_n(por_n), .d(bclk_pin_i), .q(pin_s)
  );

  bclk_edge_count #(.EDGE_THRESH(EDGE_THRESH), .GAP_CYC(GAP_CYC)) u_edges (
    .clk(clk_mst), .rst_n(por_n), .pin_s(pin_s), .clr(clr),
    .rise(rise), .active(active)
  );

  bclk_mode_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk(clk_mst), .rst_n(por_n), .rel_s(rel_s), .rise(rise),
    .active(active), .mode(mode), .clr(clr), .drv_en(drv_en)
  );

  bclk_div2 u_div (
    .clk(clk_mst), .rst_n(por_n), .en(drv_en), .bclk(bclk_o)
  );

  // Raw link reset gates the driver so the pin is released at once.
  assign bclk_oe    = drv_en & link_rst_n;
  assign src_mode_o = mode;
endmodule

// File: rtl/bclk_src_sel_chk.sv
module bclk_src_sel_chk (
  input logic       clk_mst,
  input logic       por_n,
  input logic       link_rst_n,
  input logic       bclk_pin_i,
  input logic       bclk_o,
  input logic       bclk_oe,
  input logic [1:0] src_mode_o
);
  a_r1_mode_legal: assert property (@(posedge clk_mst) disable iff (!por_n)
    src_mode_o != 2'b11);

  a_r8_oe_off_in_reset: assert property (@(posedge clk_mst) disable iff (!por_n)
    !link_rst_n |-> !bclk_oe);

  a_r8_oe_only_driver: assert property (@(posedge clk_mst) disable iff (!por_n)
    bclk_oe |-> src_mode_o == 2'b10);

  a_r7_toggle: assert property (@(posedge clk_mst) disable iff (!por_n)
    (src_mode_o == 2'b10 && $past(src_mode_o) == 2'b10 && $past(src_mode_o, 2) == 2'b10)
      |-> bclk_o != $past(bclk_o));

  a_r7_idle_low: assert property (@(posedge clk_mst) disable iff (!por_n)
    src_mode_o != 2'b10 |-> !bclk_o);

  a_r9_latched: assert property (@(posedge clk_mst) disable iff (!por_n)
    ($past(src_mode_o) != 2'b00 && src_mode_o != $past(src_mode_o)) |-> src_mode_o == 2'b00);

  a_r4_driver_from_undec: assert property (@(posedge clk_mst) disable iff (!por_n)
    (src_mode_o == 2'b10 && $past(src_mode_o) != 2'b10) |-> $past(src_mode_o) == 2'b00);
endmodule

bind bclk_src_sel bclk_src_sel_chk u_chk (
  .clk_mst(clk_mst), .por_n(por_n), .link_rst_n(link_rst_n),
  .bclk_pin_i(bclk_pin_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
  .src_mode_o(src_mode_o)
);

// File: tb/bclk_src_sel_tb_top.sv
`timescale 1ns/1ps
module bclk_src_sel_tb_top;
  localparam int THR = 3;
  localparam int GAP = 12;
  localparam int TMO = 40;

  logic       clk_mst = 1'b0;
  logic       por_n = 1'b0;
  logic       link_rst_n = 1'b0;
  logic       bclk_pin_i = 1'b0;
  logic       bclk_o, bclk_oe;
  logic [1:0] src_mode_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk_mst = ~clk_mst;

  bclk_src_sel #(.SYNC_STAGES(2), .EDGE_THRESH(THR), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_mst(clk_mst), .por_n(por_n), .link_rst_n(link_rst_n),
    .bclk_pin_i(bclk_pin_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .src_mode_o(src_mode_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_mst);
  endtask

  task automatic pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      bclk_pin_i = 1'b1;
      idle(half);
      bclk_pin_i = 1'b0;
      idle(half);
    end
  endtask

  task automatic back_to_reset();
    link_rst_n = 1'b0;
    idle(GAP + 10);
  endtask

  task automatic t_reset_state();
    chk(src_mode_o == 2'b00, "R1 status", src_mode_o, 0);
    chk(bclk_oe == 1'b0, "R1 oe", bclk_oe, 0);
    chk(bclk_o == 1'b0, "R1 bclk", bclk_o, 0);
  endtask

  task automatic t_consumer_in_reset();
    pulses(THR, 2);
    idle(6);
    chk(src_mode_o == 2'b01, "R2 consumer while reset held", src_mode_o, 1);
    chk(bclk_oe == 1'b0, "R8 oe in consumer", bclk_oe, 0);
    link_rst_n = 1'b1;
    idle(TMO + 10);
    chk(src_mode_o == 2'b01, "R9 consumer holds after release", src_mode_o, 1);
    chk(bclk_oe == 1'b0, "R8 oe stays low", bclk_oe, 0);
    chk(bclk_o == 1'b0, "R7 no clock in consumer", bclk_o, 0);
    link_rst_n = 1'b0;
    idle(4);
    chk(src_mode_o == 2'b00, "R9 undecided after assertion", src_mode_o, 0);
    idle(GAP + 10);
  endtask

  task automatic t_short_and_sparse();
    pulses(THR - 1, 2);
    idle(GAP + 10);
    chk(src_mode_o == 2'b00, "R3 short run", src_mode_o, 0);
    pulses(THR - 1, 2);
    idle(GAP + 10);
    chk(src_mode_o == 2'b00, "R3 counts cleared by gap", src_mode_o, 0);
    pulses(THR + 2, 20);
    idle(6);
    chk(src_mode_o == 2'b00, "R3 sparse edges", src_mode_o, 0);
    idle(GAP + 10);
  endtask

  task automatic t_timeout_driver();
    logic prev;
    link_rst_n = 1'b1;
    repeat (TMO + 2) @(posedge clk_mst);
    @(negedge clk_mst);
    chk(src_mode_o == 2'b00, "R4 not yet driver", src_mode_o, 0);
    @(posedge clk_mst);
    @(negedge clk_mst);
    chk(src_mode_o == 2'b10, "R4 driver at timeout", src_mode_o, 2);
    idle(2);
    chk(bclk_oe == 1'b1, "R7 oe in driver", bclk_oe, 1);
    prev = bclk_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_mst);
      chk(bclk_o != prev, "R7 divide by two", bclk_o, !prev);
      prev = bclk_o;
    end
    link_rst_n = 1'b0;
    #1;
    chk(bclk_oe == 1'b0, "R8 oe drops with reset", bclk_oe, 0);
    repeat (2) @(posedge clk_mst);
    @(negedge clk_mst);
    chk(src_mode_o == 2'b10, "R9 mode held through sync", src_mode_o, 2);
    @(posedge clk_mst);
    @(negedge clk_mst);
    chk(src_mode_o == 2'b00, "R9 undecided on third edge", src_mode_o, 0);
    chk(bclk_o == 1'b0, "R7 clock stops", bclk_o, 0);
    back_to_reset();
  endtask

  task automatic t_restart();
    link_rst_n = 1'b1;
    idle(20);
    pulses(1, 2);
    idle(TMO + 3 - 24);
    chk(src_mode_o == 2'b00, "R5 timeout restarted by edge", src_mode_o, 0);
    idle(TMO);
    chk(src_mode_o == 2'b10, "R5 driver after restarted timeout", src_mode_o, 2);
    back_to_reset();
  endtask

  task automatic t_late_burst();
    link_rst_n = 1'b1;
    idle(10);
    pulses(THR, 2);
    idle(6);
    chk(src_mode_o == 2'b01, "R6 late burst gives consumer", src_mode_o, 1);
    idle(TMO + 10);
    chk(src_mode_o == 2'b01, "R6 consumer holds", src_mode_o, 1);
    chk(bclk_oe == 1'b0, "R8 oe low after late burst", bclk_oe, 0);
    back_to_reset();
  endtask

  initial begin
    forever begin
      @(posedge clk_mst);
      cyc++;
      if (cyc > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    t_reset_state();
    por_n = 1'b1;
    idle(3);
    t_reset_state();
    t_consumer_in_reset();
    t_short_and_sparse();
    t_timeout_driver();
    t_restart();
    t_late_burst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule